// File: doc/BRIEF.md
# Section BIP-8 Error Monitor

This block checks the section-level bit-interleaved parity of a received SONET/SDH stream. Every byte of a frame enters an 8-lane even-parity accumulator. This happens before descrambling, so the bytes that travel unscrambled are included as received. When the next frame starts, the finished parity is kept as the reference for that frame. The B1 byte of the following frame has already been descrambled upstream, and it is compared with this reference when the B1 slot marker arrives.

A mismatch raises a one-cycle error flag. It also adds to a saturating running count. In bit mode the count grows by the number of differing bit positions. In block mode it grows by one per errored frame. A performance-monitoring strobe copies the running count into a 16-bit holding register and starts a new interval.

A three-state controller decides when a comparison is valid. The states are HUNT, PRIME and CHECK:
- **HUNT to PRIME:** a frame start arrives while the framer reports in-frame.
- **PRIME to CHECK:** the next frame start arrives, so one whole frame has been accumulated.
- **Back to HUNT:** PRIME or CHECK return to HUNT whenever in-frame drops.
- **Staying put:** CHECK stays in CHECK otherwise.

Top module: `b1_bip8_monitor`

## Requirements
- R1: The parity of a frame is the bytewise XOR (even parity per bit lane, bit i of the result covers bit i of every byte) of all bytes with `byte_valid` high. The sum runs from the byte flagged by `frame_start` up to, but not including, the next such byte.
- R2: The reference parity of one frame is compared with `b1_value`, sampled on the valid byte flagged by `b1_slot` in the following frame.
- R3: With `block_mode` = 0, each comparison adds the number of mismatched bits (0 to 8) to the running count.
- R4: With `block_mode` = 1, each comparison with any mismatch adds exactly one to the running count.
- R5: `frame_err` is high for exactly the one cycle after a B1 byte whose comparison mismatches, and low otherwise.
- R6: A cycle with `pm_strobe` high loads `held_count` with the running count and restarts the running count. `held_count` changes at no other time.
- R7: The running count, and so `held_count`, stops at 0xFFFF instead of wrapping.
- R8: An error whose count update falls in the strobe cycle (the strobe in the cycle right after the B1 byte) is not in the transferred value. It starts the new interval instead.
- R9: No comparison is made while `in_frame` is low, nor for the B1 byte of the first frame after the controller leaves HUNT.
- R10: After reset `held_count` is 0, `frame_err` is 0 and the controller is in HUNT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_byte | input | 8 | Received byte, still scrambled |
| byte_valid | input | 1 | `rx_byte` carries a frame byte this cycle |
| frame_start | input | 1 | Current byte is the first byte of a frame |
| b1_slot | input | 1 | Current byte position is the B1 byte |
| b1_value | input | 8 | Descrambled B1 value, read with `b1_slot` |
| in_frame | input | 1 | Framer reports frame alignment |
| block_mode | input | 1 | 1 = block counting, 0 = bit counting |
| pm_strobe | input | 1 | Performance-monitoring transfer strobe |
| held_count | output | 16 | Error count of the last closed interval |
| frame_err | output | 1 | One-cycle pulse on a B1 mismatch |

## Verification
Two situations are hardest to reach from the ports.

The first is the strobe that meets a pending count update, which has a one-cycle window. The bench drives the strobe on exactly the byte after a deliberately errored B1. It then checks that the held value excludes that error and that the next interval contains it.

The second is saturation, which needs more than 8191 fully errored frames. A long run with every B1 bit inverted in bit mode reaches it.

Loss and regain of alignment are forced by dropping `in_frame` at frame boundaries. The first frame after regain is sent with a corrupted B1, so it shows whether the priming frame is wrongly compared.

// File: rtl/b1_pkg.sv
package b1_pkg;

    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_PRIME = 2'd1,
        ST_CHECK = 2'd2
    } chk_state_t;

    function automatic int unsigned ones_in(input logic [31:0] v, input int unsigned w);
        int unsigned n;
        n = 0;
        for (int unsigned i = 0; i < w; i++) begin
            n += int'(v[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/b1_frame_fsm.sv
module b1_frame_fsm
    import b1_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_valid,
    input  logic       frame_start,
    input  logic       b1_slot,
    input  logic       in_frame,
    output chk_state_t state,
    output logic       cmp_en
);

    chk_state_t state_nx;
    logic       fs_hit;

    assign fs_hit = byte_valid && frame_start;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_HUNT;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HUNT: begin
                if (in_frame && fs_hit) state_nx = ST_PRIME;
            end
            ST_PRIME: begin
                if (!in_frame)   state_nx = ST_HUNT;
                else if (fs_hit) state_nx = ST_CHECK;
            end
            ST_CHECK: begin
                if (!in_frame)   state_nx = ST_HUNT;
            end
            default: state_nx = ST_HUNT;
        endcase
    end

    always_comb begin
        cmp_en = 1'b0;
        unique case (state)
            ST_HUNT:  cmp_en = 1'b0;
            ST_PRIME: cmp_en = 1'b0;
            ST_CHECK: cmp_en = in_frame && byte_valid && b1_slot;
            default:  cmp_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/b1_parity_acc.sv
module b1_parity_acc #(
    parameter int BIP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_valid,
    input  logic             frame_start,
    input  logic [BIP_W-1:0] rx_byte,
    output logic [BIP_W-1:0] ref_parity
);

    for (genvar g = 0; g < BIP_W; g++) begin : g_lane
        logic acc_bit;
        logic ref_bit;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                acc_bit <= 1'b0;
                ref_bit <= 1'b0;
            end else if (byte_valid) begin
                if (frame_start) begin
                    ref_bit <= acc_bit;
                    acc_bit <= rx_byte[g];
                end else begin
                    acc_bit <= acc_bit ^ rx_byte[g];
                end
            end
        end
        assign ref_parity[g] = ref_bit;
    end

endmodule

// File: rtl/b1_compare.sv
module b1_compare
    import b1_pkg::*;
#(
    parameter int BIP_W = 8,
    parameter int INC_W = $clog2(BIP_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_en,
    input  logic             block_mode,
    input  logic [BIP_W-1:0] ref_parity,
    input  logic [BIP_W-1:0] b1_value,
    output logic [INC_W-1:0] inc_q,
    output logic             err_q
);

    logic [BIP_W-1:0] diff;
    logic [INC_W-1:0] bit_errs;

    assign diff     = ref_parity ^ b1_value;
    assign bit_errs = INC_W'(ones_in(32'(diff), BIP_W));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inc_q <= '0;
            err_q <= 1'b0;
        end else if (cmp_en) begin
            err_q <= |diff;
            inc_q <= block_mode ? INC_W'(|diff) : bit_errs;
        end else begin
            inc_q <= '0;
            err_q <= 1'b0;
        end
    end

endmodule

// File: rtl/b1_err_counter.sv
module b1_err_counter #(
    parameter int CNT_W = 16,
    parameter int INC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [INC_W-1:0] inc,
    input  logic             pm_strobe,
    output logic [CNT_W-1:0] running,
    output logic [CNT_W-1:0] held
);

    localparam logic [CNT_W:0] CNT_MAX = {1'b0, {CNT_W{1'b1}}};

    logic [CNT_W:0]   sum;
    logic [CNT_W-1:0] sat_sum;

    assign sum     = {1'b0, running} + (CNT_W + 1)'(inc);
    assign sat_sum = (sum > CNT_MAX) ? CNT_MAX[CNT_W-1:0] : sum[CNT_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= '0;
            held    <= '0;
        end else if (pm_strobe) begin
            held    <= running;
            running <= CNT_W'(inc);
        end else begin
            running <= sat_sum;
        end
    end

endmodule

// File: rtl/b1_bip8_monitor.sv
module b1_bip8_monitor
    import b1_pkg::*;
#(
    parameter int BIP_W = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BIP_W-1:0] rx_byte,
    input  logic             byte_valid,
    input  logic             frame_start,
    input  logic             b1_slot,
    input  logic [BIP_W-1:0] b1_value,
    input  logic             in_frame,
    input  logic             block_mode,
    input  logic             pm_strobe,
    output logic [CNT_W-1:0] held_count,
    output logic             frame_err
);

    localparam int INC_W = $clog2(BIP_W + 1);

    chk_state_t       state;
    logic             cmp_en;
    logic [BIP_W-1:0] ref_parity;
    logic [INC_W-1:0] inc_q;
    logic [CNT_W-1:0] running;

    b1_frame_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .byte_valid  (byte_valid),
        .frame_start (frame_start),
        .b1_slot     (b1_slot),
        .in_frame    (in_frame),
        .state       (state),
        .cmp_en      (cmp_en)
    );

    b1_parity_acc #(.BIP_W(BIP_W)) u_acc (
        .clk         (clk),
        .rst_n       (rst_n),
        .byte_valid  (byte_valid),
        .frame_start (frame_start),
        .rx_byte     (rx_byte),
        .ref_parity  (ref_parity)
    );

    b1_compare #(.BIP_W(BIP_W), .INC_W(INC_W)) u_cmp (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmp_en      (cmp_en),
        .block_mode  (block_mode),
        .ref_parity  (ref_parity),
        .b1_value    (b1_value),
        .inc_q       (inc_q),
        .err_q       (frame_err)
    );

    b1_err_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .inc         (inc_q),
        .pm_strobe   (pm_strobe),
        .running     (running),
        .held        (held_count)
    );

endmodule

// File: rtl/b1_bip8_checker.sv
module b1_bip8_checker
    import b1_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             byte_valid,
    input logic             b1_slot,
    input logic             in_frame,
    input logic             pm_strobe,
    input logic             frame_err,
    input logic [CNT_W-1:0] held_count,
    input logic [CNT_W-1:0] running,
    input chk_state_t       state
);

    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    AST_LOSS_TO_HUNT: assert property (@(posedge clk) disable iff (!rst_n) !in_frame |=> state == ST_HUNT); // R9
    AST_NO_ERR_UNFRAMED: assert property (@(posedge clk) disable iff (!rst_n) !in_frame |=> !frame_err); // R9
    AST_ERR_AFTER_B1: assert property (@(posedge clk) disable iff (!rst_n) frame_err |-> $past(b1_slot && byte_valid)); // R5
    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) frame_err |=> !frame_err); // R5
    AST_STROBE_XFER: assert property (@(posedge clk) disable iff (!rst_n) pm_strobe |=> held_count == $past(running)); // R6
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n) !pm_strobe |=> $stable(held_count)); // R6
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (running == TOP && !pm_strobe) |=> running == TOP); // R7
    AST_RUN_NONDEC: assert property (@(posedge clk) disable iff (!rst_n) !pm_strobe |=> running >= $past(running)); // R7

endmodule

bind b1_bip8_monitor b1_bip8_checker #(.CNT_W(CNT_W)) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_valid (byte_valid),
    .b1_slot    (b1_slot),
    .in_frame   (in_frame),
    .pm_strobe  (pm_strobe),
    .frame_err  (frame_err),
    .held_count (held_count),
    .running    (running),
    .state      (state)
);

// File: tb/tb_b1_bip8_monitor.sv
`timescale 1ns/1ps
module tb_b1_bip8_monitor;

    localparam int FLEN   = 8;
    localparam int B1_IDX = 3;
    localparam int WDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        byte_valid = 1'b0;
    logic        frame_start = 1'b0;
    logic        b1_slot = 1'b0;
    logic [7:0]  b1_value = '0;
    logic        in_frame = 1'b0;
    logic        block_mode = 1'b0;
    logic        pm_strobe = 1'b0;
    logic [15:0] held_count;
    logic        frame_err;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    logic [7:0] prev_par = '0;
    int  since_acq = 0;
    int  exp_run = 0;
    int  exp_held = 0;

    always #10 clk = ~clk;

    b1_bip8_monitor dut (
        .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .byte_valid(byte_valid),
        .frame_start(frame_start), .b1_slot(b1_slot), .b1_value(b1_value),
        .in_frame(in_frame), .block_mode(block_mode), .pm_strobe(pm_strobe),
        .held_count(held_count), .frame_err(frame_err)
    );

    function automatic int pop8(input logic [7:0] v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += int'(v[i]);
        return n;
    endfunction

    function automatic int sat16(input int v);
        return (v > 65535) ? 65535 : v;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_frame(input logic [7:0] mask, input bit strobe_mid);
        logic [7:0] par = '0;
        int inc = 0;
        bit exp_fe = 1'b0;
        for (int i = 0; i < FLEN; i++) begin
            logic [7:0] d = 8'($urandom);
            @(negedge clk);
            if (i == B1_IDX + 1) check("R5 frame_err after B1", int'(frame_err), int'(exp_fe));
            if (i == B1_IDX + 2 && strobe_mid) check("R8 held excludes coincident error", int'(held_count), exp_held);
            rx_byte     = d;
            byte_valid  = 1'b1;
            frame_start = (i == 0);
            b1_slot     = (i == B1_IDX);
            b1_value    = prev_par ^ mask;
            pm_strobe   = strobe_mid && (i == B1_IDX + 1);
            par ^= d;
            if (i == B1_IDX) begin
                bit cmp = in_frame && (since_acq >= 1);
                exp_fe = cmp && (mask != 8'h00);
                inc = !cmp ? 0 : (block_mode ? int'(mask != 8'h00) : pop8(mask));
            end
            if (i == B1_IDX + 1) begin
                if (strobe_mid) begin
                    exp_held = exp_run;
                    exp_run  = inc;
                end else begin
                    exp_run = sat16(exp_run + inc);
                end
            end
        end
        prev_par = par;
        if (in_frame) since_acq++;
    endtask

    task automatic strobe_check(input string req);
        @(negedge clk);
        byte_valid = 1'b0;
        frame_start = 1'b0;
        b1_slot = 1'b0;
        pm_strobe = 1'b1;
        exp_held = exp_run;
        exp_run = 0;
        @(negedge clk);
        pm_strobe = 1'b0;
        check(req, int'(held_count), exp_held);
    endtask

    task automatic set_frame(input logic v);
        in_frame = v;
        if (!v) since_acq = 0;
    endtask

    initial begin
        while (cycles < WDOG) begin
            @(posedge clk);
            cycles++;
        end
        bad++;
        total++;
        $display("FAIL watchdog expired actual=%0d expected=<%0d", cycles, WDOG);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4021));
        repeat (3) @(negedge clk);
        check("R10 held after reset", int'(held_count), 0);
        check("R10 frame_err after reset", int'(frame_err), 0);
        rst_n = 1'b1;

        // R9: first frame after acquisition is not compared
        set_frame(1'b1);
        run_frame(8'hFF, 1'b0);
        run_frame(8'hFF, 1'b0);
        strobe_check("R9 priming frame skipped, next one counted");

        // R1 R2 R3: random data, bit mode
        block_mode = 1'b0;
        for (int k = 0; k < 30; k++) begin
            logic [7:0] m = ($urandom % 3 == 0) ? 8'($urandom) : 8'h00;
            run_frame(m, 1'b0);
        end
        strobe_check("R3 bit-mode interval count");
        run_frame(8'h00, 1'b0);
        strobe_check("R1 clean frame gives zero");

        // R4: block mode
        block_mode = 1'b1;
        for (int k = 0; k < 30; k++) begin
            logic [7:0] m = ($urandom % 2 == 0) ? 8'($urandom) : 8'h00;
            run_frame(m, 1'b0);
        end
        run_frame(8'hA5, 1'b0);
        strobe_check("R4 block-mode interval count");

        // R8: strobe coincides with count update
        block_mode = 1'b0;
        run_frame(8'h03, 1'b0);
        run_frame(8'h0F, 1'b1);
        strobe_check("R8 coincident error in new interval");

        // R9: loss of alignment and regain
        set_frame(1'b0);
        run_frame(8'hFF, 1'b0);
        run_frame(8'hFF, 1'b0);
        set_frame(1'b1);
        run_frame(8'hFF, 1'b0);
        run_frame(8'h01, 1'b0);
        run_frame(8'h81, 1'b0);
        strobe_check("R9 no count while unframed or priming");

        // R6: empty interval, held reloads with zero
        strobe_check("R6 empty interval transfer");

        // R7: saturation
        for (int k = 0; k < 8200; k++) run_frame(8'hFF, 1'b0);
        strobe_check("R7 saturated count");
        strobe_check("R6 cleared after saturation");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule